// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback). It lets an instruction in execute use a result that an older instruction has produced but not yet written to the register file. Without it, the instruction would have to wait for writeback.

For each of the two source registers of the instruction in execute, the block compares the register number against the destinations of the two older instructions. One older instruction sits in the execute/memory pipeline register and the other in the memory/writeback pipeline register. It then chooses one of three values:

- the value read from the register file;
- the ALU result carried in the execute/memory register;
- the data carried in the memory/writeback register, which is the loaded word for a load and the ALU result otherwise.

Each older stage names its destination with a flag: the rd field for register-to-register operations, the rt field for loads. The forwarded second source drives both the store-data output and, unless an immediate replaces it, the second ALU operand.

The block is purely combinational. The case of a load followed at once by a consumer is not resolved here; the stall logic must hold the consumer for one cycle. After that stall, the load sits in the memory/writeback stage and this block forwards it.

Top module: `operand_bypass`

## Requirements
- R1: When no older stage supplies a source, its select is 00 and the operand equals the register-file value for that source.
- R2: When the execute/memory stage writes a register equal to a source, that source's select is 10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/writeback stage writes a register equal to a source, the select is 01 and the operand equals the loaded data if that stage holds a load, else its ALU result.
- R4: When both older stages write the same register as a source, the execute/memory stage wins (select 10).
- R5: A source register number of 0 is never forwarded: its select is 00 and the register-file value is used, whatever the older stages hold.
- R6: A stage whose register-write flag is clear is never forwarded from, even if its destination matches.
- R7: Each older stage's destination is its rd field when its rd-select flag is 1 and its rt field when the flag is 0; the other field has no effect on forwarding.
- R8: The store-data output always equals the forwarded second-source value. The second ALU operand equals the immediate when the immediate flag is 1, and the forwarded second-source value when the flag is 0.
- R9: The two sources are resolved independently, so each may take a different path in the same cycle.
- R10: Select code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_W | First source register number of the instruction in execute |
| ex_rt | input | REG_W | Second source register number of the instruction in execute |
| rf_rs_val | input | DATA_W | Register-file value read for the first source |
| rf_rt_val | input | DATA_W | Register-file value read for the second source |
| ex_use_imm | input | 1 | Second ALU operand is the immediate |
| ex_imm | input | DATA_W | Sign-extended immediate |
| exm_wr | input | 1 | Execute/memory instruction writes a register |
| exm_dst_rd | input | 1 | Execute/memory destination is its rd field (1) or rt field (0) |
| exm_rd | input | REG_W | Execute/memory rd field |
| exm_rt | input | REG_W | Execute/memory rt field |
| exm_alu | input | DATA_W | Execute/memory ALU result |
| mwb_wr | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst_rd | input | 1 | Memory/writeback destination is its rd field (1) or rt field (0) |
| mwb_rd | input | REG_W | Memory/writeback rd field |
| mwb_rt | input | REG_W | Memory/writeback rt field |
| mwb_is_load | input | 1 | Memory/writeback instruction is a load |
| mwb_alu | input | DATA_W | Memory/writeback ALU result |
| mwb_mem | input | DATA_W | Memory/writeback loaded data |
| sel_a | output | 2 | First-source select: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Second-source select, same encoding |
| opnd_a | output | DATA_W | First ALU operand |
| opnd_b | output | DATA_W | Second ALU operand |
| store_data | output | DATA_W | Forwarded second-source value for stores |

## Verification
The bench builds the block with REG_W = 3 and DATA_W = 16. With eight register numbers, random stimulus makes the two sources collide often with each older stage's rd and rt fields and with register 0. This produces double matches, same-source-on-both-lanes cases and destination-field swaps every few cycles. The narrow data width keeps the forwarded values distinct per stage, so a wrong select shows up as a wrong operand. Directed cases cover the priority, register-0, write-flag and destination-field corners by name.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic [DATA_W-1:0] rf_rs_val,
  input  logic [DATA_W-1:0] rf_rt_val,
  input  logic              ex_use_imm,
  input  logic [DATA_W-1:0] ex_imm,
  input  logic              exm_wr,
  input  logic              exm_dst_rd,
  input  logic [REG_W-1:0]  exm_rd,
  input  logic [REG_W-1:0]  exm_rt,
  input  logic [DATA_W-1:0] exm_alu,
  input  logic              mwb_wr,
  input  logic              mwb_dst_rd,
  input  logic [REG_W-1:0]  mwb_rd,
  input  logic [REG_W-1:0]  mwb_rt,
  input  logic              mwb_is_load,
  input  logic [DATA_W-1:0] mwb_alu,
  input  logic [DATA_W-1:0] mwb_mem,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] store_data
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b10;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam int         NSRC    = 2;

  logic [REG_W-1:0]  exm_dst, mwb_dst;
  logic              exm_live, mwb_live;
  logic [DATA_W-1:0] mwb_val;

  assign exm_dst  = exm_dst_rd ? exm_rd : exm_rt;
  assign mwb_dst  = mwb_dst_rd ? mwb_rd : mwb_rt;
  assign exm_live = exm_wr && (exm_dst != '0);
  assign mwb_live = mwb_wr && (mwb_dst != '0);
  assign mwb_val  = mwb_is_load ? mwb_mem : mwb_alu;

  logic [REG_W-1:0]  src   [NSRC];
  logic [DATA_W-1:0] rfv   [NSRC];
  logic [1:0]        sel   [NSRC];
  logic [DATA_W-1:0] value [NSRC];

  assign src[0] = ex_rs;
  assign src[1] = ex_rt;
  assign rfv[0] = rf_rs_val;
  assign rfv[1] = rf_rt_val;

  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    logic hit_exm, hit_mwb;
    assign hit_exm = exm_live && (exm_dst == src[g]);
    assign hit_mwb = mwb_live && (mwb_dst == src[g]);
    always_comb begin
      if (hit_exm) begin
        sel[g]   = SEL_EXM;
        value[g] = exm_alu;
      end else if (hit_mwb) begin
        sel[g]   = SEL_MWB;
        value[g] = mwb_val;
      end else begin
        sel[g]   = SEL_RF;
        value[g] = rfv[g];
      end
    end
  end

  assign sel_a      = sel[0];
  assign sel_b      = sel[1];
  assign opnd_a     = value[0];
  assign store_data = value[1];
  assign opnd_b     = ex_use_imm ? ex_imm : value[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [REG_W-1:0]  ex_rs,
  input logic [REG_W-1:0]  ex_rt,
  input logic [DATA_W-1:0] rf_rs_val,
  input logic [DATA_W-1:0] rf_rt_val,
  input logic              ex_use_imm,
  input logic [DATA_W-1:0] ex_imm,
  input logic              exm_wr,
  input logic [DATA_W-1:0] exm_alu,
  input logic              mwb_wr,
  input logic              mwb_is_load,
  input logic [DATA_W-1:0] mwb_alu,
  input logic [DATA_W-1:0] mwb_mem,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] store_data
);
  always_comb begin
    if (!$isunknown({sel_a, sel_b, opnd_a, opnd_b, store_data, ex_rs, ex_rt, exm_wr, mwb_wr, ex_use_imm})) begin
      assert_code_legal_R10: assert (sel_a != 2'b11 && sel_b != 2'b11);
      assert_rf_path_R1: assert (sel_a != 2'b00 || opnd_a == rf_rs_val);
      assert_exm_path_R2: assert ((sel_a != 2'b10 || opnd_a == exm_alu) && (sel_b != 2'b10 || store_data == exm_alu));
      assert_mwb_path_R3: assert (sel_a != 2'b01 || opnd_a == (mwb_is_load ? mwb_mem : mwb_alu));
      assert_zero_reg_R5: assert ((ex_rs != '0 || sel_a == 2'b00) && (ex_rt != '0 || sel_b == 2'b00));
      assert_no_writer_R6: assert (exm_wr || mwb_wr || (sel_a == 2'b00 && sel_b == 2'b00));
      assert_imm_mux_R8: assert (ex_use_imm ? (opnd_b == ex_imm) : (opnd_b == store_data));
      assert_store_rf_R8: assert (sel_b != 2'b00 || store_data == rf_rt_val);
    end
  end
endmodule

bind operand_bypass operand_bypass_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .ex_rs(ex_rs), .ex_rt(ex_rt), .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
  .ex_use_imm(ex_use_imm), .ex_imm(ex_imm), .exm_wr(exm_wr), .exm_alu(exm_alu),
  .mwb_wr(mwb_wr), .mwb_is_load(mwb_is_load), .mwb_alu(mwb_alu), .mwb_mem(mwb_mem),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b), .store_data(store_data)
);

// File: tb/test_operand_bypass.sv
module test_operand_bypass;
  localparam int DW = 16;
  localparam int RW = 3;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [RW-1:0] ex_rs, ex_rt, exm_rd, exm_rt, mwb_rd, mwb_rt;
  logic [DW-1:0] rf_rs_val, rf_rt_val, ex_imm, exm_alu, mwb_alu, mwb_mem;
  logic ex_use_imm, exm_wr, exm_dst_rd, mwb_wr, mwb_dst_rd, mwb_is_load;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, store_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  operand_bypass #(.DATA_W(DW), .REG_W(RW)) i_operand_bypass (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
    .ex_use_imm(ex_use_imm), .ex_imm(ex_imm),
    .exm_wr(exm_wr), .exm_dst_rd(exm_dst_rd), .exm_rd(exm_rd), .exm_rt(exm_rt), .exm_alu(exm_alu),
    .mwb_wr(mwb_wr), .mwb_dst_rd(mwb_dst_rd), .mwb_rd(mwb_rd), .mwb_rt(mwb_rt),
    .mwb_is_load(mwb_is_load), .mwb_alu(mwb_alu), .mwb_mem(mwb_mem),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b), .store_data(store_data)
  );

  // Reference: walk producers from oldest to newest; a newer hit overwrites an older one.
  function automatic void model(input int src, input logic [DW-1:0] rf,
                                output logic [1:0] s, output logic [DW-1:0] v);
    int dst[2];
    bit wr[2];
    logic [DW-1:0] val[2];
    logic [1:0] code[2];
    dst[0] = mwb_dst_rd ? int'(mwb_rd) : int'(mwb_rt);
    wr[0] = mwb_wr; val[0] = mwb_is_load ? mwb_mem : mwb_alu; code[0] = 2'b01;
    dst[1] = exm_dst_rd ? int'(exm_rd) : int'(exm_rt);
    wr[1] = exm_wr; val[1] = exm_alu; code[1] = 2'b10;
    s = 2'b00; v = rf;
    for (int k = 0; k < 2; k++)
      if (wr[k] && src != 0 && dst[k] == src) begin s = code[k]; v = val[k]; end
  endfunction

  function automatic string classify(input int src);
    int de = exm_dst_rd ? int'(exm_rd) : int'(exm_rt);
    int dm = mwb_dst_rd ? int'(mwb_rd) : int'(mwb_rt);
    bit he = exm_wr && de == src;
    bit hm = mwb_wr && dm == src;
    if (src == 0) return "R5";
    if (he && hm) return "R4";
    if (he) return "R2";
    if (hm) return "R3";
    return "R1";
  endfunction

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [1:0] sa, sb;
    logic [DW-1:0] va, vb;
    string ta, tb;
    @(negedge clk);
    model(int'(ex_rs), rf_rs_val, sa, va);
    model(int'(ex_rt), rf_rt_val, sb, vb);
    ta = (tag == "") ? classify(int'(ex_rs)) : tag;
    tb = (tag == "") ? classify(int'(ex_rt)) : tag;
    check(ta, "sel_a", DW'(sel_a), DW'(sa));
    check(ta, "opnd_a", opnd_a, va);
    check(tb, "sel_b", DW'(sel_b), DW'(sb));
    check("R8", "store_data", store_data, vb);
    check("R8", "opnd_b", opnd_b, ex_use_imm ? ex_imm : vb);
    n_run++;
    if (sel_a == 2'b11 || sel_b == 2'b11) begin
      n_fail++;
      $display("FAIL R10 illegal code: actual %b/%b expected not 11", sel_a, sel_b);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic clear();
    ex_rs = 0; ex_rt = 0; rf_rs_val = 16'h1111; rf_rt_val = 16'h2222;
    ex_use_imm = 0; ex_imm = 16'h7e7e;
    exm_wr = 0; exm_dst_rd = 1; exm_rd = 0; exm_rt = 0; exm_alu = 16'haaaa;
    mwb_wr = 0; mwb_dst_rd = 1; mwb_rd = 0; mwb_rt = 0;
    mwb_is_load = 0; mwb_alu = 16'hbbbb; mwb_mem = 16'hcccc;
  endtask

  initial begin
    clear();
    #1;
    step("R1");                                   // idle after start
    ex_rs = 3; ex_rt = 4; step("R1");             // no writers at all
    exm_wr = 1; exm_rd = 3; step("R2");           // execute/memory hit on rs
    clear(); ex_rs = 5; ex_rt = 5;
    mwb_wr = 1; mwb_rd = 5; step("R3");           // writeback ALU result
    mwb_is_load = 1; mwb_dst_rd = 0; mwb_rt = 5; mwb_rd = 2; step("R3"); // writeback load data
    exm_wr = 1; exm_rd = 5; step("R4");           // both hit, newer wins
    clear(); ex_rs = 0; ex_rt = 0;
    exm_wr = 1; exm_rd = 0; mwb_wr = 1; mwb_rd = 0; step("R5"); // register 0
    clear(); ex_rs = 6; ex_rt = 6;
    exm_wr = 0; exm_rd = 6; mwb_wr = 0; mwb_rd = 6; step("R6"); // flags clear
    clear(); ex_rs = 2; ex_rt = 7;
    exm_wr = 1; exm_dst_rd = 0; exm_rd = 2; exm_rt = 7; step("R7"); // rt field names dest
    exm_dst_rd = 1; step("R7");                   // rd field names dest
    clear(); ex_rs = 1; ex_rt = 2;
    exm_wr = 1; exm_rd = 1; mwb_wr = 1; mwb_rd = 2; step("R9"); // split paths
    ex_use_imm = 1; step("R8");                   // immediate replaces ALU B, store still forwarded
    clear();
    for (int i = 0; i < 3000; i++) begin
      ex_rs = RW'($urandom); ex_rt = RW'($urandom);
      rf_rs_val = DW'($urandom); rf_rt_val = DW'($urandom);
      ex_use_imm = 1'($urandom); ex_imm = DW'($urandom);
      exm_wr = 1'($urandom); exm_dst_rd = 1'($urandom);
      exm_rd = RW'($urandom); exm_rt = RW'($urandom); exm_alu = DW'($urandom);
      mwb_wr = 1'($urandom); mwb_dst_rd = 1'($urandom);
      mwb_rd = RW'($urandom); mwb_rt = RW'($urandom); mwb_is_load = 1'($urandom);
      mwb_alu = DW'($urandom); mwb_mem = DW'($urandom);
      step("");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule